// File: doc/BRIEF.md
# Tiled SRAM array composer

This block presents one synchronous single-port memory of arbitrary logical width and depth, optionally with a per-group write mask, and builds it from a grid of smaller fixed-size RAM tiles. Tile columns divide the data word into bit slices. Tile rows divide the address range. The upper address bits pick the row, and every tile sees the lower address bits directly.

Each tile's enables and mask are derived from the logical port. Tiles return read data one cycle after the read. A registered copy of the row select therefore steers the matching row onto the output, so the output follows the row that was read and not the current address. A behavioural tile model with one cycle of read latency is part of the project.

Tile width, tile depth, tile mask granularity, tile read-enable presence and logical read-enable presence are all parameters. Bad combinations are rejected at elaboration.

Top module: `tiled_sram`

## Requirements
- R1: The data word is split into contiguous slices of the slice width, starting from bit 0. The slice width is the tile width, or the logical mask granularity when that is smaller than both the tile width and the tile mask granularity. The last slice holds the leftover bits. A full-word write followed by a read returns the written word, including the leftover slice.
- R2: When the depth exceeds the tile depth, address bits [clog2(DEPTH)-1 : clog2(TILE_D)] select the tile row. Words at equal low addresses in different rows are stored independently.
- R3: A read (ce=1 with the read condition true) presents the word on `rdata` after the next rising clock edge. `rdata` holds while no further read occurs.
- R4: The row select that steers `rdata` is registered. It loads only when ce is high and the read condition is true: re=1 if the logical read enable is used, otherwise any ce cycle. Changing `addr` without a read leaves `rdata` unchanged.
- R5: Only the tile row that matches the live address receives chip enable or write enable, and no row is enabled while ce is low.
- R6: With a logical mask of granularity G, bit k of `wmask` enables the write of data bits [G*k+G-1 : G*k]. Unmasked groups keep their old contents.
- R7: A write with `wmask` all zero leaves the stored word unchanged.
- R8: When the registered row select names no existing row (depth is not a power of two), `rdata` is zero. A write to such an address changes no stored word.
- R9: When tiles have a read enable and the logical read enable is unused, a tile reads only when it is not being written. After a write, `rdata` keeps the last word read from that row.
- R10: With ce low, a write request changes no stored word.
- R11: When the logical port is unmasked but the tiles are masked, every tile mask bit is driven high, so `wmask` has no effect on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low reset of the registered row select |
| ce | input | 1 | Chip enable of the logical port |
| re | input | 1 | Read enable (used when USE_RE=1) |
| we | input | 1 | Write enable |
| addr | input | clog2(DEPTH) | Word address |
| wdata | input | DATA_W | Write data |
| wmask | input | DATA_W/MASK_GRAN, or 1 when unmasked | Write mask, one bit per group |
| rdata | output | DATA_W | Read data, one cycle after the read |

## Verification
The bench builds two instances. The first is 20 bits by 48 words with 4-bit mask groups, over 8-bit by 16-word tiles whose mask groups are 8 bits. Its slice width falls to 4, so five columns leave the upper tile bits idle, and its three rows leave the fourth select value unmapped; this exercises the fine mask path and the zero-output default. The second is 20 bits by 64 words, unmasked, over masked tiles with no logical read enable. Its three columns end in a 4-bit leftover slice, and it exercises the all-ones tile mask and the read enable derived from the write enable.

// File: rtl/tile_ram.sv
module tile_ram #(
  parameter int W  = 16,
  parameter int D  = 64,
  parameter int MG = 8,
  localparam int AW = $clog2(D),
  localparam int MW = W / MG
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [MW-1:0] wmask,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];
  logic [W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) begin
        for (int k = 0; k < MW; k++) begin
          if (wmask[k]) mem[addr][k*MG +: MG] <= wdata[k*MG +: MG];
        end
      end
      if (re) rd_q <= mem[addr];
    end
  end

  assign rdata = rd_q;
endmodule

// File: rtl/tiled_sram.sv
module tiled_sram #(
  parameter int DATA_W         = 32,
  parameter int DEPTH          = 256,
  parameter int MASK_GRAN      = 8,
  parameter int TILE_W         = 16,
  parameter int TILE_D         = 64,
  parameter bit TILE_MASK      = 1'b1,
  parameter int TILE_MASK_GRAN = 8,
  parameter bit TILE_RE        = 1'b1,
  parameter bit USE_RE         = 1'b1,
  localparam int AW     = $clog2(DEPTH),
  localparam bit MASKED = MASK_GRAN < DATA_W,
  localparam int NMB    = MASKED ? DATA_W / MASK_GRAN : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              re,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NMB-1:0]    wmask,
  output logic [DATA_W-1:0] rdata
);
  localparam int TAW    = $clog2(TILE_D);
  localparam int NROW   = DEPTH / TILE_D;
  localparam int SELW   = AW - TAW;
  localparam int SELW_S = SELW > 0 ? SELW : 1;
  localparam int TMG    = TILE_MASK ? TILE_MASK_GRAN : TILE_W;
  localparam int TMW    = TILE_W / TMG;
  localparam int SW     = (MASKED && MASK_GRAN < TILE_W && (!TILE_MASK || TILE_MASK_GRAN > MASK_GRAN))
                          ? MASK_GRAN : TILE_W;
  localparam int NCOL   = (DATA_W + SW - 1) / SW;

  if (DEPTH % TILE_D != 0) begin : g_bad_depth
    $error("DEPTH must be a multiple of TILE_D");
  end
  if (TILE_D < 2) begin : g_bad_tile_d
    $error("TILE_D must be at least 2");
  end
  if (MASKED && ((MASK_GRAN & (MASK_GRAN - 1)) != 0 || DATA_W % MASK_GRAN != 0)) begin : g_bad_mg
    $error("MASK_GRAN must be a power of two dividing DATA_W");
  end
  if (TILE_MASK && ((TILE_MASK_GRAN & (TILE_MASK_GRAN - 1)) != 0 || TILE_W % TILE_MASK_GRAN != 0)) begin : g_bad_tmg
    $error("TILE_MASK_GRAN must be a power of two dividing TILE_W");
  end
  if (MASKED && !TILE_MASK && MASK_GRAN > TILE_W && MASK_GRAN % TILE_W != 0) begin : g_bad_align
    $error("MASK_GRAN must be a multiple of TILE_W for unmasked tiles");
  end

  logic [SELW_S-1:0]             bank, sel_q;
  logic [NROW-1:0]               row_hit, row_ce, row_we, row_re;
  logic [NROW-1:0][DATA_W-1:0]   rd_row;
  logic                          rd_req;

  if (SELW > 0) begin : g_bank
    assign bank = addr[AW-1:TAW];
  end else begin : g_nobank
    assign bank = '0;
  end

  assign rd_req = USE_RE ? (ce & re) : ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (rd_req) sel_q <= bank;
  end

  for (genvar r = 0; r < NROW; r++) begin : g_match
    assign row_hit[r] = (bank == SELW_S'(r));
    assign row_ce[r]  = ce & row_hit[r];
    assign row_we[r]  = we & row_hit[r];
    if (!TILE_RE)    begin : g_re_tie
      assign row_re[r] = 1'b1;
    end else if (USE_RE) begin : g_re_pass
      assign row_re[r] = re & row_hit[r];
    end else begin : g_re_derive
      assign row_re[r] = ~we & row_hit[r];
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int LO = c * SW;
    localparam int CW = (c == NCOL - 1) ? DATA_W - LO : SW;
    logic [TMW-1:0]    cmask;
    logic              gate;
    logic [TILE_W-1:0] twd;

    assign twd = TILE_W'(wdata[LO +: CW]);

    if (TILE_MASK) begin : g_tm
      for (genvar k = 0; k < TMW; k++) begin : g_bit
        localparam int OFF = k * TMG;
        localparam int IX0 = (LO + OFF) / MASK_GRAN;
        localparam int IX  = IX0 < NMB ? IX0 : NMB - 1;
        if (!MASKED) begin : g_all
          assign cmask[k] = 1'b1;
        end else if (OFF >= SW) begin : g_idle
          assign cmask[k] = 1'b0;
        end else begin : g_take
          assign cmask[k] = wmask[IX];
        end
      end
      assign gate = 1'b1;
    end else begin : g_nm
      assign cmask = '1;
      if (MASKED) begin : g_gate
        assign gate = wmask[LO / MASK_GRAN];
      end else begin : g_open
        assign gate = 1'b1;
      end
    end

    for (genvar r = 0; r < NROW; r++) begin : g_row
      logic [TILE_W-1:0] trd;
      tile_ram #(.W(TILE_W), .D(TILE_D), .MG(TMG)) u_tile (
        .clk  (clk),
        .ce   (row_ce[r]),
        .we   (row_we[r] & gate),
        .re   (row_re[r]),
        .addr (addr[TAW-1:0]),
        .wdata(twd),
        .wmask(cmask),
        .rdata(trd)
      );
      assign rd_row[r][LO +: CW] = trd[CW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NROW; r++) begin
      if (sel_q == SELW_S'(r)) rdata = rd_row[r];
    end
  end
endmodule

// File: rtl/tiled_sram_chk.sv
module tiled_sram_chk #(
  parameter int DATA_W = 32,
  parameter int NROW   = 4,
  parameter int SELW_S = 2,
  parameter bit USE_RE = 1'b1,
  parameter bit TILE_RE = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              re,
  input logic              we,
  input logic [SELW_S-1:0] bank,
  input logic [SELW_S-1:0] sel_q,
  input logic [NROW-1:0]   row_ce,
  input logic [NROW-1:0]   row_we,
  input logic [NROW-1:0]   row_re,
  input logic [DATA_W-1:0] rdata
);
  logic rd_cond;
  assign rd_cond = ce && (re || !USE_RE);

  a_r4_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cond |=> sel_q == $past(bank));

  a_r4_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cond |=> $stable(sel_q));

  a_r5_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_ce));

  a_r5_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_we));

  a_r5_ce_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> row_ce == '0);

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, sel_q} >= (SELW_S + 1)'(NROW)) |-> rdata == '0);

  a_r9_no_read_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (TILE_RE && !USE_RE && we) |-> row_re == '0);
endmodule

bind tiled_sram tiled_sram_chk #(
  .DATA_W(DATA_W), .NROW(NROW), .SELW_S(SELW_S), .USE_RE(USE_RE), .TILE_RE(TILE_RE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .re(re), .we(we),
  .bank(bank), .sel_q(sel_q), .row_ce(row_ce), .row_we(row_we),
  .row_re(row_re), .rdata(rdata)
);

// File: tb/tiled_sram_tb.sv
`timescale 1ns/1ps
module tiled_sram_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        ceA = 0, reA = 0, weA = 0;
  logic [5:0]  adA = 0;
  logic [19:0] wdA = 0;
  logic [4:0]  wmA = 0;
  logic [19:0] rdA;

  logic        ceB = 0, reB = 0, weB = 0;
  logic [5:0]  adB = 0;
  logic [19:0] wdB = 0;
  logic [0:0]  wmB = 0;
  logic [19:0] rdB;

  logic [19:0] refA [64];
  logic [19:0] refB [64];

  tiled_sram #(.DATA_W(20), .DEPTH(48), .MASK_GRAN(4), .TILE_W(8), .TILE_D(16),
               .TILE_MASK(1'b1), .TILE_MASK_GRAN(8), .TILE_RE(1'b1), .USE_RE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ceA), .re(reA), .we(weA), .addr(adA),
    .wdata(wdA), .wmask(wmA), .rdata(rdA));

  tiled_sram #(.DATA_W(20), .DEPTH(64), .MASK_GRAN(20), .TILE_W(8), .TILE_D(16),
               .TILE_MASK(1'b1), .TILE_MASK_GRAN(4), .TILE_RE(1'b1), .USE_RE(1'b0)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .ce(ceB), .re(reB), .we(weB), .addr(adB),
    .wdata(wdB), .wmask(wmB), .rdata(rdB));

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic opA(input logic c, input logic r, input logic w, input logic [5:0] a,
                     input logic [19:0] d, input logic [4:0] m);
    @(negedge clk);
    ceA = c; reA = r; weA = w; adA = a; wdA = d; wmA = m;
    @(negedge clk);
    ceA = 0; reA = 0; weA = 0;
  endtask

  task automatic writeA(input logic [5:0] a, input logic [19:0] d, input logic [4:0] m);
    opA(1, 0, 1, a, d, m);
    if (a < 48) for (int k = 0; k < 5; k++) if (m[k]) refA[a][4*k +: 4] = d[4*k +: 4];
  endtask

  task automatic opB(input logic c, input logic w, input logic [5:0] a,
                     input logic [19:0] d, input logic m);
    @(negedge clk);
    ceB = c; reB = 0; weB = w; adB = a; wdB = d; wmB = m;
    @(negedge clk);
    ceB = 0; weB = 0;
  endtask

  task automatic t_fill;
    for (int a = 0; a < 48; a++) writeA(6'(a), 20'((a * 32'h3A5B + 32'h1234) & 32'hFFFFF), 5'h1F);
    for (int a = 0; a < 64; a++) begin
      opB(1, 1, 6'(a), 20'((a * 32'h51C7 + 32'hF00F0) & 32'hFFFFF), 1'b1);
      refB[a] = 20'((a * 32'h51C7 + 32'hF00F0) & 32'hFFFFF);
    end
  endtask

  task automatic t_rows;
    opA(1, 1, 0, 6'd3, '0, '0);  chk("R1 R3 row0 word", rdA, refA[3]);
    opA(1, 1, 0, 6'd19, '0, '0); chk("R2 row1 same low addr", rdA, refA[19]);
    opA(1, 1, 0, 6'd35, '0, '0); chk("R2 row2 same low addr", rdA, refA[35]);
    opB(1, 0, 6'd63, '0, 0);     chk("R1 leftover slice top row", rdB, refB[63]);
    opB(1, 0, 6'd28, '0, 0);     chk("R2 config B row1", rdB, refB[28]);
  endtask

  task automatic t_hold;
    opA(1, 1, 0, 6'd19, '0, '0);
    opA(1, 0, 0, 6'd35, '0, '0); chk("R4 addr change without read", rdA, refA[19]);
    opA(0, 1, 0, 6'd3, '0, '0);  chk("R3 ce low holds output", rdA, refA[19]);
    @(negedge clk);              chk("R3 idle cycles hold output", rdA, refA[19]);
  endtask

  task automatic t_mask;
    writeA(6'd20, 20'hABCDE, 5'b01010);
    opA(1, 1, 0, 6'd20, '0, '0); chk("R6 nibble mask", rdA, refA[20]);
    writeA(6'd21, 20'h55555, 5'b00000);
    opA(1, 1, 0, 6'd21, '0, '0); chk("R7 zero mask write", rdA, refA[21]);
    writeA(6'd40, 20'h0F0F0, 5'b10001);
    opA(1, 1, 0, 6'd40, '0, '0); chk("R6 edge nibbles", rdA, refA[40]);
  endtask

  task automatic t_ce;
    opA(0, 0, 1, 6'd22, 20'h12345, 5'h1F);
    opA(1, 1, 0, 6'd22, '0, '0); chk("R10 write with ce low", rdA, refA[22]);
  endtask

  task automatic t_unmapped;
    writeA(6'd52, 20'hFFFFF, 5'h1F);
    opA(1, 1, 0, 6'd52, '0, '0); chk("R8 unmapped row reads zero", rdA, 20'h0);
    opA(1, 1, 0, 6'd4, '0, '0);  chk("R8 row0 alias untouched", rdA, refA[4]);
    opA(1, 1, 0, 6'd36, '0, '0); chk("R8 row2 alias untouched", rdA, refA[36]);
  endtask

  task automatic t_derived_re;
    opB(1, 0, 6'd7, '0, 0);
    opB(1, 1, 6'd9, 20'h0BEEF, 0);
    refB[9] = 20'h0BEEF;
    chk("R9 write does not read", rdB, refB[7]);
    opB(1, 0, 6'd9, '0, 0);      chk("R11 mask low ignored", rdB, refB[9]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_fill();
    t_rows();
    t_hold();
    t_mask();
    t_ce();
    t_unmapped();
    t_derived_re();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule